// File: doc/BRIEF.md
# Bulk-In Receive Release Controller

This block decides, for every bulk-in request from the host, whether the receive FIFO answers with a data packet or with a NAK. When a packet is sent, the block also gives its byte count. By default it holds data back until one full maximum-size packet has built up. Three conditions end that wait early. The first is an idle timeout: a request is answered once more than three character times have passed without a new character. The second is a low-latency control bit, which releases any buffered data at once. The third is an automatic low-latency signal, which turns on when the programmed baud divisor gives a line rate below 46921 bps.

The maximum packet size depends on bus speed: 512 bytes at high speed and 64 bytes at full speed. The FIFO storage and the USB protocol framing are outside this block. It reads the FIFO fill level, a received-character strobe and a character-time tick, and returns a registered one-cycle response for each request.

Top module: `bulk_release_ctrl`

## Requirements
- R1: After reset the response outputs are low, and the idle timer starts at zero, so a partial-packet request right after reset is NAKed.
- R2: The maximum packet size is 512 bytes when `highSpeed` is 1 and 64 bytes when it is 0.
- R3: If the fill level is at least the maximum packet size, a request is ACKed and `respCount` equals the maximum packet size.
- R4: A request that arrives while the fill level is 0 is always NAKed, whatever the low-latency, baud and idle state.
- R5: If the fill level is between 1 and one less than the maximum packet size, low latency is off, and no more than 3 character ticks have passed since the last character, the request is NAKed.
- R6: Once 4 or more character ticks have passed with no received character, a partial-packet request is ACKed with `respCount` equal to the fill level. The idle timer saturates and stays expired under further ticks.
- R7: A received-character strobe resets the idle timer to zero. If a strobe and a tick come in the same cycle, the reset wins.
- R8: While `lowLatency` is 1, any nonzero partial level is ACKed at once with `respCount` equal to the level.
- R9: `autoLowLat` is 1 exactly when `baudDiv * 46921 > 48000000` (a line rate below 46921 bps from a 48 MHz reference). A divisor of 0 gives 0. While it is 1, requests behave as if low latency were on.
- R10: `respValid` is a single-cycle pulse in the cycle after `bulkReq` is sampled. On a NAK, `respAck` is 0 and `respCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoLevel | input | 11 | Bytes currently held in the receive FIFO |
| highSpeed | input | 1 | 1 = high-speed bus (512-byte packets), 0 = full speed (64) |
| rxCharStb | input | 1 | One-cycle pulse for each received character |
| charTick | input | 1 | One-cycle pulse once per character time |
| lowLatency | input | 1 | Control bit: release any buffered data at once |
| baudDiv | input | 16 | Programmed baud divisor against the 48 MHz reference |
| bulkReq | input | 1 | One-cycle pulse for a host bulk-in request |
| respValid | output | 1 | Response pulse, one cycle after the request |
| respAck | output | 1 | 1 = send packet, 0 = NAK |
| respCount | output | 11 | Bytes to transfer (0 on NAK) |
| autoLowLat | output | 1 | Baud rate is below the low-latency threshold |

## Verification
The bench probes the packet-size edges on both bus speeds: levels of 511/512 and 63/64. A compare that is off by one would send a full packet early or hold one back. It counts ticks to the idle edge, expecting a NAK after three ticks and an ACK after the fourth. A timer that expired after three would release too early, and one that failed to saturate would wrap around and start NAKing again. It also checks that a character and a tick arriving in the same cycle leave the timer cleared, and that an empty FIFO is NAKed even when low latency is on. Finally it tests divisors 1022 and 1023 around the baud threshold and a zero divisor, any of which a flipped comparison would get wrong.

// File: rtl/brc_pkg.sv
package brc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrIdle;
    logic stepIdle;
    logic issue;
    logic grant;
    logic sendFull;
  } ctrlStb_t;

  // status from datapath to control
  typedef struct packed {
    logic empty;
    logic fullPkt;
    logic idleDone;
    logic slowBaud;
  } dpFlags_t;
endpackage

// File: rtl/brc_datapath.sv
module brc_datapath
  import brc_pkg::*;
#(
  parameter int LVL_W      = 11,
  parameter int HS_PKT     = 512,
  parameter int FS_PKT     = 64,
  parameter int IDLE_CHARS = 3,
  parameter int DIV_W      = 16,
  parameter int REF_HZ     = 48000000,
  parameter int SLOW_BAUD  = 46921
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             highSpeed,
  input  logic [DIV_W-1:0] baudDiv,
  input  ctrlStb_t         stb,
  output dpFlags_t         flags,
  output logic             respValid,
  output logic             respAck,
  output logic [LVL_W-1:0] respCount
);
  localparam int IDLE_LIM = IDLE_CHARS + 1;
  localparam int IDLE_W   = $clog2(IDLE_LIM + 1);
  localparam int PROD_W   = DIV_W + 32;

  logic [IDLE_W-1:0] idleCnt;
  logic [LVL_W-1:0]  maxPkt;
  logic [PROD_W-1:0] rateProd;

  assign maxPkt   = highSpeed ? LVL_W'(HS_PKT) : LVL_W'(FS_PKT);
  assign rateProd = PROD_W'(baudDiv) * PROD_W'(SLOW_BAUD);

  assign flags.empty    = (fifoLevel == '0);
  assign flags.fullPkt  = (fifoLevel >= maxPkt);
  assign flags.idleDone = (idleCnt == IDLE_W'(IDLE_LIM));
  assign flags.slowBaud = (rateProd > PROD_W'(REF_HZ));

  // idle timer in character times, saturating one past the limit
  always_ff @(posedge clk) begin
    if (!rstN)                 idleCnt <= '0;
    else if (stb.clrIdle)      idleCnt <= '0;
    else if (stb.stepIdle && idleCnt != IDLE_W'(IDLE_LIM))
                               idleCnt <= idleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respAck   <= 1'b0;
      respCount <= '0;
    end else begin
      respValid <= stb.issue;
      respAck   <= stb.issue && stb.grant;
      if (stb.issue && stb.grant) respCount <= stb.sendFull ? maxPkt : fifoLevel;
      else                        respCount <= '0;
    end
  end

  assert_nak_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respAck) |-> (respCount == '0));
  assert_ack_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    respAck |-> (respCount != '0));
  assert_ack_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    respAck |-> (respCount <= LVL_W'(HS_PKT)));
  assert_ack_in_resp_R10: assert property (@(posedge clk) disable iff (!rstN)
    respAck |-> respValid);
  assert_idle_sat_R6: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_W'(IDLE_LIM));
  assert_char_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrIdle |=> (idleCnt == '0));
endmodule

// File: rtl/brc_control.sv
module brc_control
  import brc_pkg::*;
(
  input  logic     rxCharStb,
  input  logic     charTick,
  input  logic     lowLatency,
  input  logic     bulkReq,
  input  dpFlags_t flags,
  output ctrlStb_t stb
);
  logic earlyRelease;

  always_comb begin
    earlyRelease = lowLatency || flags.slowBaud || flags.idleDone;
    stb.clrIdle  = rxCharStb;
    stb.stepIdle = charTick;
    stb.issue    = bulkReq;
    stb.grant    = !flags.empty && (flags.fullPkt || earlyRelease);
    stb.sendFull = flags.fullPkt;
  end
endmodule

// File: rtl/bulk_release_ctrl.sv
module bulk_release_ctrl
  import brc_pkg::*;
#(
  parameter int LVL_W      = 11,
  parameter int HS_PKT     = 512,
  parameter int FS_PKT     = 64,
  parameter int IDLE_CHARS = 3,
  parameter int DIV_W      = 16,
  parameter int REF_HZ     = 48000000,
  parameter int SLOW_BAUD  = 46921
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             highSpeed,
  input  logic             rxCharStb,
  input  logic             charTick,
  input  logic             lowLatency,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             bulkReq,
  output logic             respValid,
  output logic             respAck,
  output logic [LVL_W-1:0] respCount,
  output logic             autoLowLat
);
  ctrlStb_t stb;
  dpFlags_t flags;

  brc_control u_ctrl (
    .rxCharStb (rxCharStb),
    .charTick  (charTick),
    .lowLatency(lowLatency),
    .bulkReq   (bulkReq),
    .flags     (flags),
    .stb       (stb)
  );

  brc_datapath #(
    .LVL_W(LVL_W), .HS_PKT(HS_PKT), .FS_PKT(FS_PKT), .IDLE_CHARS(IDLE_CHARS),
    .DIV_W(DIV_W), .REF_HZ(REF_HZ), .SLOW_BAUD(SLOW_BAUD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fifoLevel(fifoLevel),
    .highSpeed(highSpeed),
    .baudDiv  (baudDiv),
    .stb      (stb),
    .flags    (flags),
    .respValid(respValid),
    .respAck  (respAck),
    .respCount(respCount)
  );

  assign autoLowLat = flags.slowBaud;

  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(bulkReq));
  assert_empty_nak_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bulkReq && fifoLevel == '0) |=> !respAck);
endmodule

// File: tb/bulk_release_ctrl_bench.sv
module bulk_release_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [10:0] fifoLevel;
  logic        highSpeed, rxCharStb, charTick, lowLatency, bulkReq;
  logic [15:0] baudDiv;
  logic        respValid, respAck, autoLowLat;
  logic [10:0] respCount;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  bulk_release_ctrl u_bulk_release_ctrl (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .highSpeed(highSpeed),
    .rxCharStb(rxCharStb), .charTick(charTick), .lowLatency(lowLatency),
    .baudDiv(baudDiv), .bulkReq(bulkReq), .respValid(respValid),
    .respAck(respAck), .respCount(respCount), .autoLowLat(autoLowLat)
  );

  // vector: {hs, ll, level[10:0], expAck, expCount[10:0]}
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 11'd512,  1'b1, 11'd512},  // R3 R2
    {1'b1, 1'b0, 11'd600,  1'b1, 11'd512},  // R3
    {1'b1, 1'b0, 11'd511,  1'b0, 11'd0},    // R5
    {1'b0, 1'b0, 11'd64,   1'b1, 11'd64},   // R2
    {1'b0, 1'b0, 11'd63,   1'b0, 11'd0},    // R5
    {1'b0, 1'b0, 11'd300,  1'b1, 11'd64},   // R2
    {1'b1, 1'b1, 11'd1,    1'b1, 11'd1},    // R8
    {1'b0, 1'b1, 11'd40,   1'b1, 11'd40},   // R8
    {1'b1, 1'b1, 11'd0,    1'b0, 11'd0},    // R4
    {1'b0, 1'b0, 11'd0,    1'b0, 11'd0},    // R4
    {1'b1, 1'b1, 11'd2047, 1'b1, 11'd512}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(input string req, input logic expAck, input logic [10:0] expCnt);
    @(negedge clk) bulkReq = 1'b1;
    @(negedge clk) bulkReq = 1'b0;
    check(req, {31'd0, respValid}, 32'd1);
    check(req, {31'd0, respAck}, {31'd0, expAck});
    check(req, {21'd0, respCount}, {21'd0, expCnt});
    @(negedge clk);
    check({req, " pulse"}, {31'd0, respValid}, 32'd0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) charTick = 1'b1;
      @(negedge clk) charTick = 1'b0;
    end
  endtask

  task automatic rxChar();
    @(negedge clk) rxCharStb = 1'b1;
    @(negedge clk) rxCharStb = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; fifoLevel = '0; highSpeed = 1'b1; rxCharStb = 1'b0;
    charTick = 1'b0; lowLatency = 1'b0; baudDiv = 16'd100; bulkReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, respValid}, 32'd0);
    check("R1 ack", {31'd0, respAck}, 32'd0);
    check("R1 count", {21'd0, respCount}, 32'd0);
    rstN = 1'b1;
    fifoLevel = 11'd10;
    request("R1 idle starts at zero", 1'b0, 11'd0);

    // table walk, idle timer fresh
    for (int v = 0; v < NV; v++) begin
      rxChar();
      highSpeed  = VEC[v][24];
      lowLatency = VEC[v][23];
      fifoLevel  = VEC[v][22:12];
      request($sformatf("R2/R3/R4/R5/R8 vec%0d", v), VEC[v][11], VEC[v][10:0]);
    end

    // idle timeout
    highSpeed = 1'b1; lowLatency = 1'b0; fifoLevel = 11'd100;
    rxChar();
    ticks(3);
    request("R5 three ticks", 1'b0, 11'd0);
    ticks(1);
    request("R6 fourth tick", 1'b1, 11'd100);
    ticks(20);
    request("R6 saturate", 1'b1, 11'd100);
    fifoLevel = 11'd0;
    request("R4 empty after idle", 1'b0, 11'd0);
    fifoLevel = 11'd100;
    rxChar();
    request("R7 char clears", 1'b0, 11'd0);

    // same-cycle char and tick
    ticks(3);
    @(negedge clk) begin rxCharStb = 1'b1; charTick = 1'b1; end
    @(negedge clk) begin rxCharStb = 1'b0; charTick = 1'b0; end
    ticks(3);
    request("R7 char wins over tick", 1'b0, 11'd0);
    ticks(1);
    request("R7 expiry after clear", 1'b1, 11'd100);

    // baud threshold
    rxChar();
    fifoLevel = 11'd5;
    baudDiv = 16'd1023;
    @(negedge clk);
    check("R9 auto 1023", {31'd0, autoLowLat}, 32'd1);
    request("R9 auto releases", 1'b1, 11'd5);
    baudDiv = 16'd1022;
    @(negedge clk);
    check("R9 auto 1022", {31'd0, autoLowLat}, 32'd0);
    request("R9 no auto holds", 1'b0, 11'd0);
    baudDiv = 16'd0;
    @(negedge clk);
    check("R9 auto zero div", {31'd0, autoLowLat}, 32'd0);
    baudDiv = 16'hFFFF;
    fifoLevel = 11'd0;
    @(negedge clk);
    check("R9 auto max div", {31'd0, autoLowLat}, 32'd1);
    request("R4 empty with auto", 1'b0, 11'd0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule